// File: doc/BRIEF.md
# DMA Request Selector and Channel Arbiter

This block sits between a bank of peripheral DMA request lines and a two-channel DMA engine that shares one bus master. Each channel is configured with an enable, the index of the request line it follows, a flag marking it as memory-paced, and a "work left" indication. From these the block derives one request per channel. It grants the single master to at most one channel at a time, with channel 0 always preferred over channel 1.

While a channel holds the grant, the block reports whether the pending transaction is a burst or a single transfer. The grant stays fixed until the engine signals the end of that transaction. The block then returns a one-cycle completion acknowledge to the peripheral line that was served, and after that it arbitrates again.

A small state machine drives the sequence through three states. ST_IDLE arbitrates and moves to ST_OWN when a request is granted. ST_OWN holds the grant and moves to ST_RELEASE on `xfer_done`. ST_RELEASE issues the acknowledge and returns unconditionally to ST_IDLE. Data movement and address generation sit outside this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `grant` is 0 and every bit of both acknowledge vectors is 0.
- R2: While `ctrl_enable` is 0, no new grant is issued.
- R3: A channel whose `ch_enable` bit is 0 never requests. Its selected line and its memory-paced flag are ignored.
- R4: A channel requests when it is enabled, its `ch_work_left` bit is 1, and either its `ch_mem_paced` bit is 1 or its selected line (bits [4c+3:4c] of `ch_line_sel` for channel c) has its single or burst request high. A request on any other line does not count.
- R5: When both channels request in the same arbitration cycle, channel 0 is granted. Channel 1 is granted at the next arbitration if it still requests.
- R6: `grant` is one-hot or zero. Bit c means channel c owns the master.
- R7: No new grant is issued while `master_busy` is 1.
- R8: Once issued, the grant does not change until the cycle after `xfer_done` is sampled high. Request changes during ownership have no effect on it.
- R9: `grant_burst` is 1 while the grant is held if, at the moment of granting, the selected line's burst request was high or the channel was memory-paced. Otherwise it is 0. A line showing both kinds counts as burst.
- R10: One clock edge after `xfer_done` is sampled with a grant held, `grant` becomes 0. For exactly one cycle, bit L of `line_burst_ack` (burst transaction) or of `line_single_ack` (single transaction) is 1, where L is the line latched at grant time. A memory-paced channel gets no acknowledge.
- R11: After the acknowledge cycle, one further cycle passes with `grant` at 0 before any new grant can appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable | input | 1 | Global controller enable |
| ch_enable | input | 2 | Per-channel enable |
| ch_line_sel | input | 8 | Per-channel selected request line, 4 bits per channel |
| ch_mem_paced | input | 2 | Channel is not peripheral-paced (always requests) |
| ch_work_left | input | 2 | Channel still has data to move |
| line_single_req | input | 16 | Single-transfer request per peripheral line |
| line_burst_req | input | 16 | Burst-transfer request per peripheral line |
| master_busy | input | 1 | Shared master cannot accept a new owner |
| xfer_done | input | 1 | Granted channel finished its current transaction |
| grant | output | 2 | One-hot master grant per channel |
| grant_burst | output | 1 | Granted transaction is a burst |
| line_single_ack | output | 16 | One-cycle single completion acknowledge per line |
| line_burst_ack | output | 16 | One-cycle burst completion acknowledge per line |

## Verification
Two events can coincide in one cycle. The first is a request from the higher-priority channel. The second is a release, which is the point where a pending lower-priority channel would otherwise take the master. The bench raises both channel requests on the same edge and keeps channel 1 requesting across channel 0's completion. It then confirms three things in turn: the acknowledge lands on channel 0's line, the gap cycle shows no grant, and channel 1 only then receives the grant with its own request type. A line that shows single and burst requests at once is swept on every line for both channels. Those cases are judged against the rule that burst wins, both in `grant_burst` and in which acknowledge vector pulses.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OWN     = 2'd1,
        ST_RELEASE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dma_req_select.sv
module dma_req_select #(
    parameter int NUM_LINES = 16,
    parameter int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 chan_on,
    input  logic                 work_left,
    input  logic                 mem_paced,
    input  logic [SEL_W-1:0]     line_idx,
    input  logic [NUM_LINES-1:0] single_lines,
    input  logic [NUM_LINES-1:0] burst_lines,
    output logic                 chan_req,
    output logic                 chan_burst
);

    logic picked_single;
    logic picked_burst;

    always_comb begin
        picked_single = single_lines[line_idx];
        picked_burst  = burst_lines[line_idx];
        // R3 / R4: gating by the channel enable comes first
        chan_req   = chan_on && work_left && (mem_paced || picked_single || picked_burst);
        // R9: burst wins when both kinds are shown
        chan_burst = mem_paced || picked_burst;
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req_vec,
    output logic              any_req,
    output logic [CH_W-1:0]   win_idx
);

    // R5: lowest channel index has the highest priority
    always_comb begin
        any_req = 1'b0;
        win_idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (req_vec[c]) begin
                any_req = 1'b1;
                win_idx = CH_W'(c);
            end
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CH    = 2,
    localparam int SEL_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_enable,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic [NUM_CH*SEL_W-1:0]   ch_line_sel,
    input  logic [NUM_CH-1:0]         ch_mem_paced,
    input  logic [NUM_CH-1:0]         ch_work_left,
    input  logic [NUM_LINES-1:0]      line_single_req,
    input  logic [NUM_LINES-1:0]      line_burst_req,
    input  logic                      master_busy,
    input  logic                      xfer_done,
    output logic [NUM_CH-1:0]         grant,
    output logic                      grant_burst,
    output logic [NUM_LINES-1:0]      line_single_ack,
    output logic [NUM_LINES-1:0]      line_burst_ack
);

    logic [NUM_CH-1:0] ch_req;
    logic [NUM_CH-1:0] ch_burst;
    logic [SEL_W-1:0]  sel_arr [NUM_CH];

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_chan
            assign sel_arr[gc] = ch_line_sel[gc*SEL_W +: SEL_W];

            dma_req_select #(
                .NUM_LINES (NUM_LINES),
                .SEL_W     (SEL_W)
            ) u_sel (
                .chan_on      (ch_enable[gc]),
                .work_left    (ch_work_left[gc]),
                .mem_paced    (ch_mem_paced[gc]),
                .line_idx     (sel_arr[gc]),
                .single_lines (line_single_req),
                .burst_lines  (line_burst_req),
                .chan_req     (ch_req[gc]),
                .chan_burst   (ch_burst[gc])
            );

            // R3: a disabled channel never presents a request
            a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_enable[gc] |-> !ch_req[gc]);
        end
    endgenerate

    logic            pick_valid;
    logic [CH_W-1:0] pick_idx;

    dma_prio_pick #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_pick (
        .req_vec (ch_req),
        .any_req (pick_valid),
        .win_idx (pick_idx)
    );

    arb_state_e       state_q, state_d;
    logic [CH_W-1:0]  owner_q;
    logic             burst_q;
    logic             mem_q;
    logic [SEL_W-1:0] line_q;
    logic             take_grant;

    assign take_grant = ctrl_enable && !master_busy && pick_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_grant) state_d = ST_OWN;
            ST_OWN:     if (xfer_done)  state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and grant context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            burst_q <= 1'b0;
            mem_q   <= 1'b0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && take_grant) begin
                owner_q <= pick_idx;
                burst_q <= ch_burst[pick_idx];
                mem_q   <= ch_mem_paced[pick_idx];
                line_q  <= sel_arr[pick_idx];
            end
        end
    end

    // outputs from state
    always_comb begin
        grant           = '0;
        grant_burst     = 1'b0;
        line_single_ack = '0;
        line_burst_ack  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OWN: begin
                for (int c = 0; c < NUM_CH; c++)
                    grant[c] = (owner_q == CH_W'(c));
                grant_burst = burst_q;
            end
            ST_RELEASE: begin
                if (!mem_q) begin
                    if (burst_q) line_burst_ack[line_q]  = 1'b1;
                    else         line_single_ack[line_q] = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R6: single master, at most one owner
    a_r6_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8: grant frozen until the transaction ends
    a_r8_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant && !xfer_done) |=> $stable(grant));

    // R10: completion drops the grant on the next edge
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant && xfer_done) |=> (grant == '0));

    // R10: at most one acknowledge bit at a time, never alongside a grant
    a_r10_ack_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({line_single_ack, line_burst_ack}) <= 1) &&
        (!(|{line_single_ack, line_burst_ack}) || grant == '0));

    // R5: channel 0 wins whenever it requests at an arbitration point
    a_r5_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl_enable && !master_busy && ch_req[0]) |=> grant[0]);

    // R7: busy master blocks new grants
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && master_busy) |=> (grant == '0));

    // R2: controller off blocks new grants
    a_r2_ctrl_off: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && !ctrl_enable) |=> (grant == '0));

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_enable;
    logic [1:0]  ch_enable;
    logic [7:0]  ch_line_sel;
    logic [1:0]  ch_mem_paced;
    logic [1:0]  ch_work_left;
    logic [15:0] line_single_req;
    logic [15:0] line_burst_req;
    logic        master_busy;
    logic        xfer_done;
    logic [1:0]  grant;
    logic        grant_burst;
    logic [15:0] line_single_ack;
    logic [15:0] line_burst_ack;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dma_req_arbiter uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_enable     (ctrl_enable),
        .ch_enable       (ch_enable),
        .ch_line_sel     (ch_line_sel),
        .ch_mem_paced    (ch_mem_paced),
        .ch_work_left    (ch_work_left),
        .line_single_req (line_single_req),
        .line_burst_req  (line_burst_req),
        .master_busy     (master_busy),
        .xfer_done       (xfer_done),
        .grant           (grant),
        .grant_burst     (grant_burst),
        .line_single_ack (line_single_ack),
        .line_burst_ack  (line_burst_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // finish the current transaction and step through release and gap
    task automatic finish_txn();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n           = 1'b0;
        ctrl_enable     = 1'b0;
        ch_enable       = 2'b01;
        ch_line_sel     = 8'h00;
        ch_mem_paced    = 2'b00;
        ch_work_left    = 2'b11;
        line_single_req = 16'h0001;
        line_burst_req  = 16'h0000;
        master_busy     = 1'b0;
        xfer_done       = 1'b0;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 grant in reset", 32'(grant), 0);
        chk("R1 acks in reset", 32'({line_single_ack, line_burst_ack}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", 32'(grant), 0);

        // R2: controller off with a live request
        repeat (3) @(negedge clk);
        chk("R2 no grant while ctrl off", 32'(grant), 0);
        ctrl_enable = 1'b1;
        @(negedge clk);
        chk("R2 grant once enabled", 32'(grant), 32'h1);
        line_single_req = '0;
        finish_txn();
        @(negedge clk);

        // R4 R8 R9 R10 R11 R3: sweep channel x line x request kind
        for (int ch = 0; ch < 2; ch++) begin
            for (int ln = 0; ln < 16; ln++) begin
                for (int k = 1; k < 4; k++) begin
                    ch_enable       = 2'(1 << ch);
                    ch_line_sel     = {4'(ln), 4'(ln)};
                    line_single_req = (k & 1) ? 16'(1 << ln) : 16'h0;
                    line_burst_req  = (k & 2) ? 16'(1 << ln) : 16'h0;
                    @(negedge clk);
                    chk("R4/R3 grant to enabled channel only", 32'(grant), 32'(1 << ch));
                    chk("R9 request kind", 32'(grant_burst), 32'(k >= 2));
                    line_single_req = '0;
                    line_burst_req  = '0;
                    @(negedge clk);
                    chk("R8 grant held after request drop", 32'(grant), 32'(1 << ch));
                    xfer_done = 1'b1;
                    @(negedge clk);
                    xfer_done = 1'b0;
                    chk("R10 grant dropped", 32'(grant), 0);
                    chk("R10 single ack", 32'(line_single_ack), (k == 1) ? 32'(1 << ln) : 0);
                    chk("R10 burst ack", 32'(line_burst_ack), (k >= 2) ? 32'(1 << ln) : 0);
                    @(negedge clk);
                    chk("R10 ack lasts one cycle", 32'({line_single_ack, line_burst_ack}), 0);
                    chk("R11 gap cycle", 32'(grant), 0);
                end
            end
        end

        // R4: request on a line other than the selected one
        ch_enable = 2'b01;
        for (int s = 0; s < 16; s++) begin
            for (int l = 0; l < 16; l++) begin
                if (l != s) begin
                    ch_line_sel     = {4'h0, 4'(s)};
                    line_single_req = 16'(1 << l);
                    line_burst_req  = 16'(1 << l);
                    @(negedge clk);
                    chk("R4 unselected line ignored", 32'(grant), 0);
                end
            end
        end
        line_single_req = '0;
        line_burst_req  = '0;

        // R3: disabled channels with live line and memory-paced flag
        ch_enable       = 2'b00;
        ch_mem_paced    = 2'b11;
        ch_line_sel     = 8'h22;
        line_single_req = 16'h0004;
        repeat (3) @(negedge clk);
        chk("R3 disabled channels ignored", 32'(grant), 0);
        ch_mem_paced    = 2'b00;
        line_single_req = '0;

        // R5: both channels request together
        ch_enable       = 2'b11;
        ch_line_sel     = {4'd9, 4'd3};
        line_single_req = 16'h0008;
        line_burst_req  = 16'h0200;
        @(negedge clk);
        chk("R5 channel 0 first", 32'(grant), 32'h1);
        chk("R5 channel 0 kind", 32'(grant_burst), 0);
        line_single_req = '0;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R5 ack on channel 0 line", 32'(line_single_ack), 32'h0008);
        @(negedge clk);
        chk("R11 gap before channel 1", 32'(grant), 0);
        @(negedge clk);
        chk("R5 channel 1 next", 32'(grant), 32'h2);
        chk("R5 channel 1 kind", 32'(grant_burst), 1);
        line_burst_req = '0;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R10 burst ack channel 1", 32'(line_burst_ack), 32'h0200);
        @(negedge clk);

        // R7: busy master
        ch_enable       = 2'b01;
        ch_line_sel     = 8'h05;
        line_single_req = 16'h0020;
        master_busy     = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 no grant while busy", 32'(grant), 0);
        master_busy = 1'b0;
        @(negedge clk);
        chk("R7 grant after busy clears", 32'(grant), 32'h1);
        line_single_req = '0;
        finish_txn();
        @(negedge clk);

        // R9 R10 R4: memory-paced channel
        ch_enable    = 2'b10;
        ch_mem_paced = 2'b10;
        @(negedge clk);
        chk("R4 memory-paced request", 32'(grant), 32'h2);
        chk("R9 memory-paced is burst", 32'(grant_burst), 1);
        ch_work_left = 2'b01;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R10 no ack for memory-paced", 32'({line_single_ack, line_burst_ack}), 0);
        repeat (3) @(negedge clk);
        chk("R4 no work left no grant", 32'(grant), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule